// File: doc/BRIEF.md
# Floating-Point Environment Image Serializer

This block turns the live environment of a floating-point unit into the word stream that a save instruction writes to memory. It takes the control, status and tag words, the instruction and operand pointers with their selectors, and the 11-bit last opcode. On a start request it emits the image one entry per cycle, as a data word, a byte offset from the image base and a byte-enable strobe. The memory side adds the base address and performs the writes.

Two inputs choose one of four layouts. The first selects protected mode or real-address mode. Virtual-8086 and system-management mode use the real-address layout. The second selects a 32-bit or 16-bit operand size. Protected layouts store pointer offsets and selectors as separate entries. Real-address layouts split each linear pointer into a low part and a high part, and the high part shares its entry with the opcode or with zero padding. When a full save is requested, the eight 80-bit data registers follow the environment as a packed byte stream. The block then pulses a reinitialize output so that the unit can return to its default state.

Top module: `fpuEnvSerializer`

## Requirements
- R1: After reset, wrValid, done, reinit and busy are all low.
- R2: When start is high while the block is idle, all inputs are sampled at that clock edge. From the next cycle, one entry is emitted per cycle with wrValid high. wrOffset starts at 0 and rises by 4 per entry in 32-bit size or by 2 in 16-bit size. wrByteEn is 4'b1111 in 32-bit size and 4'b0011 in 16-bit size. The environment is always seven entries.
- R3: 32-bit protected layout, entries 0 to 6: control, status and tag each zero-extended to 32 bits; the full instruction pointer; {5'b0, opcode, instruction selector}; the full operand pointer; {16'b0, operand selector}.
- R4: 32-bit real layout, entries 3 to 6: {16'b0, IP[15:0]}; {4'b0, IP[31:16], 1'b0, opcode}; {16'b0, OP[15:0]}; {4'b0, OP[31:16], 12'b0}. Entries 0 to 2 are the same as in R3.
- R5: 16-bit protected layout: control, status, tag, IP[15:0], instruction selector, OP[15:0], operand selector. The opcode is not stored, and wrData[31:16] is zero.
- R6: 16-bit real layout, entries 3 to 6: IP[15:0]; {IP[19:16], 1'b0, opcode}; OP[15:0]; {OP[19:16], 12'b0}. wrData[31:16] is zero.
- R7: With fullSave, 80 register bytes follow the environment, starting at offset 28 (32-bit size) or 14 (16-bit size). The order is R0 to R7, with bit 0 of dataRegs belonging to R0. Within each register the least significant byte comes first, and the lowest byte of each entry sits in wrData[7:0].
- R8: done is high for exactly one cycle, in the cycle after the last entry. busy is low from that same cycle.
- R9: reinit is high together with done only when the save was a full save. Otherwise it stays low.
- R10: A start request while busy is ignored. Input changes after the accepting edge do not alter the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a save |
| realMode | input | 1 | 1 selects a real-address layout |
| wide32 | input | 1 | 1 selects the 32-bit operand size |
| fullSave | input | 1 | 1 appends the data registers and requests a reinitialize |
| ctrlWord | input | 16 | Control word |
| statWord | input | 16 | Status word |
| tagWord | input | 16 | Tag word |
| instPtr | input | 32 | Instruction pointer (offset or linear) |
| instSel | input | 16 | Instruction selector |
| operPtr | input | 32 | Operand pointer (offset or linear) |
| operSel | input | 16 | Operand selector |
| lastOpcode | input | 11 | Last opcode, low 11 bits |
| dataRegs | input | 640 | Eight 80-bit data registers, R0 in the low bits |
| busy | output | 1 | A save is in progress |
| wrValid | output | 1 | Write strobe for the current entry |
| wrOffset | output | 8 | Byte offset of the entry from the image base |
| wrByteEn | output | 4 | Byte enables of wrData |
| wrData | output | 32 | Entry data, lowest byte in bits 7:0 |
| done | output | 1 | One-cycle pulse after the last entry |
| reinit | output | 1 | One-cycle reinitialize pulse after a full save |

## Verification
The assertions check several properties on every cycle. The offset starts at zero and steps by the entry size. In 16-bit size the upper data half stays zero. done and reinit are single-cycle pulses, and reinit never appears without done. The index advances exactly one entry per cycle while a save runs, even when start is asserted again. Only the bench scenarios can show the actual field packing of each of the four layouts, the byte order of the register area, that the inputs are held from the accepting edge, and which kind of save raises reinit. The bench compares every emitted entry against an image it builds from the layout requirements.

// File: rtl/fpuEnvPkg.sv
package fpuEnvPkg;
  parameter int NUM_REGS    = 8;
  parameter int REG_BITS    = 80;
  parameter int ENV_ENTRIES = 7;
  parameter int BUS_BITS    = 32;
  parameter int PTR_BITS    = 32;
  parameter int OPC_BITS    = 11;

  localparam int REG_BYTES  = NUM_REGS * REG_BITS / 8;
  localparam int UNITS_WIDE = REG_BYTES / 4;
  localparam int UNITS_NARR = REG_BYTES / 2;
  localparam int MAX_ENTRY  = ENV_ENTRIES + UNITS_NARR;
  localparam int IDX_W      = $clog2(MAX_ENTRY);
  localparam int OFF_W      = $clog2(MAX_ENTRY * 2) + 1;
  localparam int BE_W       = BUS_BITS / 8;

  typedef struct packed {
    logic             capture;
    logic             emit;
    logic [IDX_W-1:0] idx;
    logic             wide;
    logic             realFmt;
  } ctlStrobes_t;
endpackage

// File: rtl/fpuEnvCtrl.sv
module fpuEnvCtrl
  import fpuEnvPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        realMode,
  input  logic        wide32,
  input  logic        fullSave,
  output ctlStrobes_t strobes,
  output logic        busy,
  output logic        done,
  output logic        reinit
);
  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  localparam logic [IDX_W-1:0] LAST_ENV  = IDX_W'(ENV_ENTRIES - 1);
  localparam logic [IDX_W-1:0] LAST_WIDE = IDX_W'(ENV_ENTRIES + UNITS_WIDE - 1);
  localparam logic [IDX_W-1:0] LAST_NARR = IDX_W'(ENV_ENTRIES + UNITS_NARR - 1);

  state_t           state;
  logic [IDX_W-1:0] idx;
  logic             wideQ, realQ, fullQ;
  logic [IDX_W-1:0] lastIdx;

  always_comb begin
    if (!fullQ)     lastIdx = LAST_ENV;
    else if (wideQ) lastIdx = LAST_WIDE;
    else            lastIdx = LAST_NARR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      idx    <= '0;
      wideQ  <= 1'b0;
      realQ  <= 1'b0;
      fullQ  <= 1'b0;
      done   <= 1'b0;
      reinit <= 1'b0;
    end else begin
      done   <= 1'b0;
      reinit <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUN;
          idx   <= '0;
          wideQ <= wide32;
          realQ <= realMode;
          fullQ <= fullSave;
        end
        ST_RUN: begin
          if (idx == lastIdx) begin
            state  <= ST_IDLE;
            done   <= 1'b1;
            reinit <= fullQ;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.capture = (state == ST_IDLE) && start;
    strobes.emit    = (state == ST_RUN);
    strobes.idx     = idx;
    strobes.wide    = wideQ;
    strobes.realFmt = realQ;
  end
  assign busy = (state == ST_RUN);

  // R8: done comes only in the first cycle without a write after a run
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!strobes.emit && $past(strobes.emit)));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R9: reinit never without done
  a_r9_reinit_with_done: assert property (@(posedge clk) disable iff (!rstN)
    reinit |-> done);
  // R10: a run advances one entry per cycle whatever start does
  a_r10_steady_advance: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.emit && $past(strobes.emit)) |-> (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/fpuEnvPath.sv
module fpuEnvPath
  import fpuEnvPkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  ctlStrobes_t                  strobes,
  input  logic [15:0]                  ctrlWord,
  input  logic [15:0]                  statWord,
  input  logic [15:0]                  tagWord,
  input  logic [PTR_BITS-1:0]          instPtr,
  input  logic [15:0]                  instSel,
  input  logic [PTR_BITS-1:0]          operPtr,
  input  logic [15:0]                  operSel,
  input  logic [OPC_BITS-1:0]          lastOpcode,
  input  logic [NUM_REGS*REG_BITS-1:0] dataRegs,
  output logic                         wrValid,
  output logic [OFF_W-1:0]             wrOffset,
  output logic [BE_W-1:0]              wrByteEn,
  output logic [BUS_BITS-1:0]          wrData
);
  localparam int SHIFT_W = $clog2(NUM_REGS * REG_BITS) + 1;

  logic [15:0]                  cwQ, swQ, twQ, isQ, osQ;
  logic [PTR_BITS-1:0]          ipQ, opQ;
  logic [OPC_BITS-1:0]          opcQ;
  logic [NUM_REGS*REG_BITS-1:0] regsQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cwQ <= '0; swQ <= '0; twQ <= '0; isQ <= '0; osQ <= '0;
      ipQ <= '0; opQ <= '0; opcQ <= '0; regsQ <= '0;
    end else if (strobes.capture) begin
      cwQ <= ctrlWord; swQ <= statWord; twQ <= tagWord;
      isQ <= instSel;  osQ <= operSel;
      ipQ <= instPtr;  opQ <= operPtr;
      opcQ <= lastOpcode;
      regsQ <= dataRegs;
    end
  end

  logic [31:0]                  envWord;
  logic [IDX_W-1:0]             regIdx;
  logic [SHIFT_W-1:0]           shiftAmt;
  logic [NUM_REGS*REG_BITS-1:0] regShifted;
  logic [31:0]                  regWord;

  always_comb begin
    envWord = '0;
    case (strobes.idx)
      IDX_W'(0): envWord = {16'b0, cwQ};
      IDX_W'(1): envWord = {16'b0, swQ};
      IDX_W'(2): envWord = {16'b0, twQ};
      IDX_W'(3): envWord = (strobes.wide && !strobes.realFmt) ? ipQ : {16'b0, ipQ[15:0]};
      IDX_W'(4): begin
        if (strobes.realFmt)
          envWord = strobes.wide ? {4'b0, ipQ[31:16], 1'b0, opcQ}
                                 : {16'b0, ipQ[19:16], 1'b0, opcQ};
        else
          envWord = strobes.wide ? {5'b0, opcQ, isQ} : {16'b0, isQ};
      end
      IDX_W'(5): envWord = (strobes.wide && !strobes.realFmt) ? opQ : {16'b0, opQ[15:0]};
      IDX_W'(6): begin
        if (strobes.realFmt)
          envWord = strobes.wide ? {4'b0, opQ[31:16], 12'b0} : {16'b0, opQ[19:16], 12'b0};
        else
          envWord = {16'b0, osQ};
      end
      default: envWord = '0;
    endcase
  end

  always_comb begin
    regIdx     = strobes.idx - IDX_W'(ENV_ENTRIES);
    shiftAmt   = strobes.wide ? (SHIFT_W'(regIdx) << 5) : (SHIFT_W'(regIdx) << 4);
    regShifted = regsQ >> shiftAmt;
    regWord    = strobes.wide ? regShifted[31:0] : {16'b0, regShifted[15:0]};
  end

  assign wrValid  = strobes.emit;
  assign wrOffset = strobes.wide ? (OFF_W'(strobes.idx) << 2) : (OFF_W'(strobes.idx) << 1);
  assign wrByteEn = strobes.wide ? {BE_W{1'b1}} : BE_W'(2'b11);
  assign wrData   = (strobes.idx < IDX_W'(ENV_ENTRIES)) ? envWord : regWord;

  // R2: an image starts at offset zero and steps by the entry size
  a_r2_first_offset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrValid) |-> (wrOffset == '0));
  a_r2_offset_step: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && $past(wrValid)) |->
      (wrOffset == $past(wrOffset) + (strobes.wide ? OFF_W'(4) : OFF_W'(2))));
  // R5/R6: the upper half of the bus is clear in 16-bit size
  a_r5_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !strobes.wide) |-> (wrData[31:16] == 16'h0));
endmodule

// File: rtl/fpuEnvSerializer.sv
module fpuEnvSerializer
  import fpuEnvPkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic                         realMode,
  input  logic                         wide32,
  input  logic                         fullSave,
  input  logic [15:0]                  ctrlWord,
  input  logic [15:0]                  statWord,
  input  logic [15:0]                  tagWord,
  input  logic [PTR_BITS-1:0]          instPtr,
  input  logic [15:0]                  instSel,
  input  logic [PTR_BITS-1:0]          operPtr,
  input  logic [15:0]                  operSel,
  input  logic [OPC_BITS-1:0]          lastOpcode,
  input  logic [NUM_REGS*REG_BITS-1:0] dataRegs,
  output logic                         busy,
  output logic                         wrValid,
  output logic [OFF_W-1:0]             wrOffset,
  output logic [BE_W-1:0]              wrByteEn,
  output logic [BUS_BITS-1:0]          wrData,
  output logic                         done,
  output logic                         reinit
);
  ctlStrobes_t strobes;

  fpuEnvCtrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .realMode(realMode),
    .wide32(wide32), .fullSave(fullSave), .strobes(strobes),
    .busy(busy), .done(done), .reinit(reinit)
  );

  fpuEnvPath uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .ctrlWord(ctrlWord), .statWord(statWord), .tagWord(tagWord),
    .instPtr(instPtr), .instSel(instSel), .operPtr(operPtr), .operSel(operSel),
    .lastOpcode(lastOpcode), .dataRegs(dataRegs),
    .wrValid(wrValid), .wrOffset(wrOffset), .wrByteEn(wrByteEn), .wrData(wrData)
  );
endmodule

// File: tb/fpuEnvSerializer_test.sv
module fpuEnvSerializer_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0, realMode = 1'b0, wide32 = 1'b0, fullSave = 1'b0;
  logic [15:0]  ctrlWord = '0, statWord = '0, tagWord = '0, instSel = '0, operSel = '0;
  logic [31:0]  instPtr = '0, operPtr = '0;
  logic [10:0]  lastOpcode = '0;
  logic [639:0] dataRegs = '0;
  logic         busy, wrValid, done, reinit;
  logic [7:0]   wrOffset;
  logic [3:0]   wrByteEn;
  logic [31:0]  wrData;

  typedef struct packed {
    logic [7:0]  off;
    logic [3:0]  be;
    logic [31:0] data;
    logic [3:0]  req;
  } item_t;

  item_t queueExp[$];
  int    compared = 0, mismatched = 0;
  bit    expFull = 1'b0;
  bit    finished = 1'b0;

  always #2.5 clk = ~clk;

  fpuEnvSerializer uut (
    .clk(clk), .rstN(rstN), .start(start), .realMode(realMode), .wide32(wide32),
    .fullSave(fullSave), .ctrlWord(ctrlWord), .statWord(statWord), .tagWord(tagWord),
    .instPtr(instPtr), .instSel(instSel), .operPtr(operPtr), .operSel(operSel),
    .lastOpcode(lastOpcode), .dataRegs(dataRegs), .busy(busy), .wrValid(wrValid),
    .wrOffset(wrOffset), .wrByteEn(wrByteEn), .wrData(wrData), .done(done), .reinit(reinit)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected environment entry built from the layout requirements R3..R6
  function automatic logic [31:0] envExp(int i, bit rm, bit wd, logic [15:0] cw, logic [15:0] sw,
      logic [15:0] tw, logic [31:0] ip, logic [15:0] is, logic [31:0] op, logic [15:0] os,
      logic [10:0] opc);
    logic [31:0] w;
    w = '0;
    case (i)
      0: w = {16'h0, cw};
      1: w = {16'h0, sw};
      2: w = {16'h0, tw};
      3: w = (wd && !rm) ? ip : {16'h0, ip[15:0]};
      4: if (rm) w = wd ? {4'h0, ip[31:16], 1'b0, opc} : {16'h0, ip[19:16], 1'b0, opc};
         else    w = wd ? {5'h0, opc, is} : {16'h0, is};
      5: w = (wd && !rm) ? op : {16'h0, op[15:0]};
      6: if (rm) w = wd ? {4'h0, op[31:16], 12'h0} : {16'h0, op[19:16], 12'h0};
         else    w = {16'h0, os};
      default: w = '0;
    endcase
    return w;
  endfunction

  task automatic runSave(input bit rm, input bit wd, input bit fs, input int seed);
    logic [7:0] rb [80];
    item_t it;
    int layoutReq;
    @(negedge clk);
    ctrlWord = 16'h037F ^ 16'(seed * 3);   statWord = 16'h4123 + 16'(seed);
    tagWord  = 16'hA5F0 ^ 16'(seed << 4);  instSel  = 16'h0BAD + 16'(seed);
    operSel  = 16'h7E11 ^ 16'(seed);       lastOpcode = 11'h5A3 ^ 11'(seed);
    instPtr  = 32'hDEAB_C123 + 32'(seed * 32'h0101_0101);
    operPtr  = 32'h8765_4321 ^ 32'(seed * 32'h0011_2233);
    for (int i = 0; i < 80; i++) begin
      rb[i] = 8'(seed * 29 + i * 11 + 3);
      dataRegs[i*8 +: 8] = rb[i];
    end
    layoutReq = wd ? (rm ? 4 : 3) : (rm ? 6 : 5);
    for (int i = 0; i < 7; i++) begin
      it.off  = wd ? 8'(i * 4) : 8'(i * 2);
      it.be   = wd ? 4'hF : 4'h3;
      it.data = envExp(i, rm, wd, ctrlWord, statWord, tagWord, instPtr, instSel,
                       operPtr, operSel, lastOpcode);
      it.req  = 4'(layoutReq);
      queueExp.push_back(it);
    end
    if (fs) begin
      for (int k = 0; k < (wd ? 20 : 40); k++) begin   // R7 register area
        it.off  = wd ? 8'(28 + 4*k) : 8'(14 + 2*k);
        it.be   = wd ? 4'hF : 4'h3;
        it.data = wd ? {rb[4*k+3], rb[4*k+2], rb[4*k+1], rb[4*k]} : {16'h0, rb[2*k+1], rb[2*k]};
        it.req  = 4'd7;
        queueExp.push_back(it);
      end
    end
    expFull = fs;
    realMode = rm; wide32 = wd; fullSave = fs; start = 1'b1;
    @(negedge clk);
    // R10: scramble every input once accepted
    start = 1'b0; realMode = ~rm; wide32 = ~wd; fullSave = ~fs;
    ctrlWord = ~ctrlWord; instPtr = ~instPtr; operPtr = ~operPtr; lastOpcode = ~lastOpcode;
    dataRegs = ~dataRegs;
    repeat (3) @(negedge clk);
    start = 1'b1;   // R10: request while busy must be ignored
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(queueExp.size() == 0, "R2 entry count", 64'(queueExp.size()), 64'd0);
  endtask

  // Monitor: pops and compares each emitted entry, watches done/reinit
  bit prevValid = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (wrValid) begin
        if (queueExp.size() == 0) begin
          check(1'b0, "R10 unexpected entry", {24'h0, wrOffset, wrData}, 64'h0);
        end else begin
          item_t e;
          e = queueExp.pop_front();
          check(wrOffset == e.off && wrByteEn == e.be, "R2 offset/strobe",
                {52'h0, wrByteEn, wrOffset}, {52'h0, e.be, e.off});
          check(wrData == e.data, $sformatf("R%0d data at offset %0d (R10 snapshot)", e.req, e.off),
                64'(wrData), 64'(e.data));
        end
      end
      if (prevValid && !wrValid) begin
        check(done == 1'b1 && busy == 1'b0, "R8 done after last", {62'h0, done, busy}, 64'h2);
        check(reinit == expFull, "R9 reinit", 64'(reinit), 64'(expFull));
      end else begin
        check(done == 1'b0 && reinit == 1'b0, "R8/R9 no stray pulse R8 R9", {62'h0, done, reinit}, 64'h0);
      end
      prevValid = wrValid;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!wrValid && !done && !reinit && !busy, "R1 reset state",
          {60'h0, wrValid, done, reinit, busy}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(!wrValid && !busy, "R1 idle after reset", {62'h0, wrValid, busy}, 64'h0);
    runSave(1'b0, 1'b1, 1'b0, 1);   // R3
    runSave(1'b1, 1'b1, 1'b0, 2);   // R4
    runSave(1'b0, 1'b0, 1'b0, 3);   // R5
    runSave(1'b1, 1'b0, 1'b0, 4);   // R6
    runSave(1'b0, 1'b1, 1'b1, 5);   // R7, R9 wide
    runSave(1'b1, 1'b0, 1'b1, 6);   // R7, R9 narrow
    runSave(1'b1, 1'b1, 1'b0, 7);   // R9 non-full after full
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule